// File: doc/BRIEF.md
# Load-Store Byte Lane Unit

This block sits between a processor core and a word-organized data memory with a one-cycle synchronous read port. For every request it forms the effective byte address. That address is the base register value plus a 16-bit offset, and the offset is treated as a signed number. The block then presents the word-aligned address to the memory. For stores it spreads the source operand across the byte lanes and raises only the write strobes of the addressed bytes.

For loads it remembers which lane was addressed, along with the access size and the fill mode. When the memory word returns one cycle later, the block picks out the addressed byte, halfword or word. It widens that value to 32 bits with either sign fill or zero fill. Lanes are numbered big-endian: byte offset 0 of a word sits in bits 31:24. A halfword or word access that is not naturally aligned raises an address-error flag and is not sent to the memory.

Top module: `lsu_byte_lane`

## Requirements
- R1: The effective address is baseAddr plus offset sign-extended to 32 bits, taken modulo 2^32. memAddr carries it with the two low bits cleared.
- R2: A byte store (reqSize 00) raises exactly one strobe. Byte offset k raises memStrobe bit 3-k, and memStrobe[3] enables bits 31:24.
- R3: A byte store replicates storeData[7:0] into all four lanes of memWdata. A halfword store replicates storeData[15:0] into both halves. A word store passes storeData through unchanged.
- R4: A halfword store (reqSize 01) raises strobes 1100 at byte offset 0 and 0011 at byte offset 2. A word store (reqSize 10 or 11) raises 1111.
- R5: A halfword access at an odd address, or a word access with a nonzero low address bit, raises addrErr. In that case memEn, memWe and all strobes stay low, and no loadValid follows.
- R6: loadValid is high in the cycle right after an accepted load, and at no other time.
- R7: A signed byte load (reqUnsigned 0) returns the addressed byte with bit 7 copied into bits 31:8.
- R8: An unsigned byte load (reqUnsigned 1) returns the addressed byte with bits 31:8 set to zero.
- R9: A halfword load returns bits 31:16 of the memory word at offset 0 and bits 15:0 at offset 2. The upper 16 bits are filled with its bit 15 when signed and with zeros when unsigned.
- R10: A word load returns memRdata unchanged.
- R11: While rstN is low and right after reset, loadValid is 0.
- R12: When reqValid is 0, memEn, memWe, addrErr and every strobe are 0, whatever the other request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 00 byte, 01 halfword, 1x word |
| reqUnsigned | input | 1 | Load fill mode: 1 = zero fill, 0 = sign fill |
| baseAddr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| storeData | input | 32 | Source register for stores |
| memAddr | output | 32 | Word-aligned memory address |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memStrobe | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| memWdata | output | 32 | Lane-replicated write data |
| memRdata | input | 32 | Word returned one cycle after a read |
| addrErr | output | 1 | Misaligned request flag |
| loadValid | output | 1 | loadData is valid this cycle |
| loadData | output | 32 | Extracted and extended load result |

## Verification
Some properties are checked on every cycle. Strobes stay silent when nothing is written. A flagged request never reaches the memory. A byte store drives a single strobe and a word store drives all four. Every loadValid follows an accepted load, and a signed byte result has a uniform upper field. The exact lane chosen for each offset cannot be judged by a generic property, and neither can the replicated write pattern, the value of the extended result, or the effect of wrapping at the address space edge. Those are shown only by the bench's vectors, which run known words and offsets through each load and store mode.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LSU_DATA_W = 32;
  localparam int LSU_LANES  = LSU_DATA_W / 8;
  localparam int LSU_LANE_W = $clog2(LSU_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRDX = 2'b11
  } accSize_e;

  typedef struct packed {
    logic                  memEn;
    logic                  memWe;
    logic                  addrErr;
    logic [LSU_LANES-1:0]  strobe;
    accSize_e              wrSize;
    logic [LSU_LANE_W-1:0] rdLane;
    accSize_e              rdSize;
    logic                  rdUnsigned;
    logic                  rdValid;
  } ctrlStrb_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [1:0]            reqSize,
  input  logic                  reqUnsigned,
  input  logic [LSU_LANE_W-1:0] lane,
  output ctrlStrb_t             ctl
);
  localparam logic [LSU_LANES-1:0] BYTE_MASK = {1'b1, {(LSU_LANES-1){1'b0}}};
  localparam logic [LSU_LANES-1:0] HALF_MASK = {2'b11, {(LSU_LANES-2){1'b0}}};

  accSize_e              sizeE;
  logic                  misaligned;
  logic                  accept;
  logic [LSU_LANES-1:0]  laneMask;
  logic                  pendValid;
  logic [LSU_LANE_W-1:0] pendLane;
  accSize_e              pendSize;
  logic                  pendUns;

  assign sizeE = accSize_e'(reqSize);

  always_comb begin
    unique case (sizeE)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lane[0];
      default: misaligned = (lane != '0);
    endcase
  end

  assign accept = reqValid && !misaligned;

  always_comb begin
    unique case (sizeE)
      SZ_BYTE: laneMask = BYTE_MASK >> lane;
      SZ_HALF: laneMask = HALF_MASK >> lane;
      default: laneMask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendLane  <= '0;
      pendSize  <= SZ_WORD;
      pendUns   <= 1'b0;
    end else begin
      pendValid <= accept && !reqWrite;
      if (accept && !reqWrite) begin
        pendLane <= lane;
        pendSize <= sizeE;
        pendUns  <= reqUnsigned;
      end
    end
  end

  always_comb begin
    ctl.memEn      = accept;
    ctl.memWe      = accept && reqWrite;
    ctl.addrErr    = reqValid && misaligned;
    ctl.strobe     = (accept && reqWrite) ? laneMask : '0;
    ctl.wrSize     = sizeE;
    ctl.rdLane     = pendLane;
    ctl.rdSize     = pendSize;
    ctl.rdUnsigned = pendUns;
    ctl.rdValid    = pendValid;
  end
endmodule

// File: rtl/lsu_data.sv
module lsu_data
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [OFF_W-1:0]      offset,
  input  logic [LSU_DATA_W-1:0] storeData,
  input  logic [LSU_DATA_W-1:0] memRdata,
  input  ctrlStrb_t             ctl,
  output logic [LSU_LANE_W-1:0] lane,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LSU_DATA_W-1:0] memWdata,
  output logic [LSU_DATA_W-1:0] loadData
);
  localparam int EXT_W  = ADDR_W - OFF_W;
  localparam int HALF_W = LSU_DATA_W / 2;

  logic [ADDR_W-1:0]     effAddr;
  logic [LSU_DATA_W-1:0] shifted;
  logic [7:0]            byteVal;
  logic [HALF_W-1:0]     halfVal;
  logic                  fillB;
  logic                  fillH;

  assign effAddr = baseAddr + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane    = effAddr[LSU_LANE_W-1:0];
  assign memAddr = {effAddr[ADDR_W-1:LSU_LANE_W], {LSU_LANE_W{1'b0}}};

  always_comb begin
    unique case (ctl.wrSize)
      SZ_BYTE: memWdata = {LSU_LANES{storeData[7:0]}};
      SZ_HALF: memWdata = {2{storeData[HALF_W-1:0]}};
      default: memWdata = storeData;
    endcase
  end

  assign shifted = memRdata << (ctl.rdLane * 8);
  assign byteVal = shifted[LSU_DATA_W-1 -: 8];
  assign halfVal = shifted[LSU_DATA_W-1 -: HALF_W];
  assign fillB   = !ctl.rdUnsigned && byteVal[7];
  assign fillH   = !ctl.rdUnsigned && halfVal[HALF_W-1];

  always_comb begin
    unique case (ctl.rdSize)
      SZ_BYTE: loadData = {{(LSU_DATA_W-8){fillB}}, byteVal};
      SZ_HALF: loadData = {{HALF_W{fillH}}, halfVal};
      default: loadData = memRdata;
    endcase
  end
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [1:0]            reqSize,
  input  logic                  reqUnsigned,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [OFF_W-1:0]      offset,
  input  logic [LSU_DATA_W-1:0] storeData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memEn,
  output logic                  memWe,
  output logic [LSU_LANES-1:0]  memStrobe,
  output logic [LSU_DATA_W-1:0] memWdata,
  input  logic [LSU_DATA_W-1:0] memRdata,
  output logic                  addrErr,
  output logic                  loadValid,
  output logic [LSU_DATA_W-1:0] loadData
);
  ctrlStrb_t             ctl;
  logic [LSU_LANE_W-1:0] lane;

  lsu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .lane(lane), .ctl(ctl)
  );

  lsu_data #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) uData (
    .baseAddr(baseAddr), .offset(offset), .storeData(storeData),
    .memRdata(memRdata), .ctl(ctl), .lane(lane), .memAddr(memAddr),
    .memWdata(memWdata), .loadData(loadData)
  );

  assign memEn     = ctl.memEn;
  assign memWe     = ctl.memWe;
  assign memStrobe = ctl.strobe;
  assign addrErr   = ctl.addrErr;
  assign loadValid = ctl.rdValid;
endmodule

// File: rtl/lsu_byte_lane_chk.sv
module lsu_byte_lane_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [1:0]  reqSize,
  input logic        reqUnsigned,
  input logic        memEn,
  input logic        memWe,
  input logic [3:0]  memStrobe,
  input logic        addrErr,
  input logic        loadValid,
  input logic [31:0] loadData
);
  // R12
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWe |-> memStrobe == 4'b0000);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memEn && !addrErr));

  // R5
  misalign_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (!memEn && !memWe));

  // R2
  byte_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && reqSize == 2'b00) |-> $countones(memStrobe) == 1);

  // R4
  word_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && reqSize[1]) |-> memStrobe == 4'b1111);

  // R6
  load_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> loadValid);

  // R6
  load_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && !memWe) |=> !loadValid);

  // R7
  sext_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe && reqSize == 2'b00 && !reqUnsigned)
      |=> (loadData[31:8] == {24{loadData[7]}}));
endmodule

bind lsu_byte_lane lsu_byte_lane_chk uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqSize(reqSize), .reqUnsigned(reqUnsigned), .memEn(memEn),
  .memWe(memWe), .memStrobe(memStrobe), .addrErr(addrErr),
  .loadValid(loadValid), .loadData(loadData)
);

// File: tb/tb_lsu_byte_lane.sv
module tb_lsu_byte_lane;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqUnsigned;
  logic [1:0]  reqSize;
  logic [31:0] baseAddr, storeData, memRdata;
  logic [15:0] offset;
  logic [31:0] memAddr, memWdata, loadData;
  logic        memEn, memWe, addrErr, loadValid;
  logic [3:0]  memStrobe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsu_byte_lane dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .baseAddr(baseAddr),
    .offset(offset), .storeData(storeData), .memAddr(memAddr),
    .memEn(memEn), .memWe(memWe), .memStrobe(memStrobe),
    .memWdata(memWdata), .memRdata(memRdata), .addrErr(addrErr),
    .loadValid(loadValid), .loadData(loadData)
  );

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        uns;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] data;   // store operand or returned memory word
    logic [31:0] eAddr;
    logic [3:0]  eStrb;
    logic [31:0] eVal;   // expected memWdata or loadData
    logic        eErr;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R2 R3 byte store lane 1 / lane 3
    '{1'b1, 2'b00, 1'b0, 32'h0000_1000, 16'h0001, 32'hAABB_CC5A, 32'h0000_1000, 4'b0100, 32'h5A5A_5A5A, 1'b0},
    '{1'b1, 2'b00, 1'b0, 32'h0000_1000, 16'h0003, 32'hAABB_CC5A, 32'h0000_1000, 4'b0001, 32'h5A5A_5A5A, 1'b0},
    '{1'b1, 2'b00, 1'b0, 32'h0000_1000, 16'h0000, 32'h0000_0011, 32'h0000_1000, 4'b1000, 32'h1111_1111, 1'b0},
    // R1 R4 halfword store, negative offset, lane 2 / lane 0
    '{1'b1, 2'b01, 1'b0, 32'h0000_2000, 16'hFFFE, 32'h1234_BEEF, 32'h0000_1FFC, 4'b0011, 32'hBEEF_BEEF, 1'b0},
    '{1'b1, 2'b01, 1'b0, 32'h0000_2000, 16'h0000, 32'h1234_BEEF, 32'h0000_2000, 4'b1100, 32'hBEEF_BEEF, 1'b0},
    // R4 word store
    '{1'b1, 2'b10, 1'b0, 32'h0000_3000, 16'h0004, 32'hCAFE_F00D, 32'h0000_3004, 4'b1111, 32'hCAFE_F00D, 1'b0},
    // R5 misaligned stores
    '{1'b1, 2'b10, 1'b0, 32'h0000_3000, 16'h0002, 32'hCAFE_F00D, 32'h0000_3000, 4'b0000, 32'h0, 1'b1},
    '{1'b1, 2'b01, 1'b0, 32'h0000_3000, 16'h0001, 32'hCAFE_F00D, 32'h0000_3000, 4'b0000, 32'h0, 1'b1},
    // R7 R8 byte loads
    '{1'b0, 2'b00, 1'b0, 32'h0000_4000, 16'h0000, 32'h8011_227F, 32'h0000_4000, 4'b0000, 32'hFFFF_FF80, 1'b0},
    '{1'b0, 2'b00, 1'b1, 32'h0000_4000, 16'h0000, 32'h8011_227F, 32'h0000_4000, 4'b0000, 32'h0000_0080, 1'b0},
    '{1'b0, 2'b00, 1'b0, 32'h0000_4000, 16'h0003, 32'h8011_227F, 32'h0000_4000, 4'b0000, 32'h0000_007F, 1'b0},
    // R9 halfword loads
    '{1'b0, 2'b01, 1'b0, 32'h0000_4000, 16'h0002, 32'h1234_9ABC, 32'h0000_4000, 4'b0000, 32'hFFFF_9ABC, 1'b0},
    '{1'b0, 2'b01, 1'b1, 32'h0000_4000, 16'h0002, 32'h1234_9ABC, 32'h0000_4000, 4'b0000, 32'h0000_9ABC, 1'b0},
    '{1'b0, 2'b01, 1'b0, 32'h0000_4000, 16'h0000, 32'h1234_9ABC, 32'h0000_4000, 4'b0000, 32'h0000_1234, 1'b0},
    // R10 word load, R5 misaligned load
    '{1'b0, 2'b10, 1'b0, 32'h0000_4004, 16'hFFFC, 32'hDEAD_BEEF, 32'h0000_4000, 4'b0000, 32'hDEAD_BEEF, 1'b0},
    '{1'b0, 2'b11, 1'b0, 32'h0000_4004, 16'h0001, 32'hDEAD_BEEF, 32'h0000_4004, 4'b0000, 32'h0, 1'b1},
    // R1 wrap past the top of the address space, R8
    '{1'b0, 2'b00, 1'b1, 32'hFFFF_FFF1, 16'h7FFF, 32'hA500_0000, 32'h0000_7FF0, 4'b0000, 32'h0000_00A5, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleReq();
    reqValid = 1'b0; reqWrite = 1'b0; reqSize = 2'b00; reqUnsigned = 1'b0;
    baseAddr = '0; offset = '0; storeData = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; memRdata = '0; idleReq();
    repeat (3) @(negedge clk);
    #1;
    chk("R11 loadValid in reset", {31'b0, loadValid}, 32'h0);
    chk("R12 memEn idle in reset", {31'b0, memEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R11 loadValid after reset", {31'b0, loadValid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reqValid = 1'b1; reqWrite = VECS[i].st; reqSize = VECS[i].sz;
      reqUnsigned = VECS[i].uns; baseAddr = VECS[i].base; offset = VECS[i].off;
      storeData = VECS[i].st ? VECS[i].data : 32'h0;
      memRdata = '0;
      #1;
      chk($sformatf("R1 memAddr v%0d", i), memAddr, VECS[i].eAddr);
      chk($sformatf("R5 addrErr v%0d", i), {31'b0, addrErr}, {31'b0, VECS[i].eErr});
      chk($sformatf("R5 memEn v%0d", i), {31'b0, memEn}, {31'b0, !VECS[i].eErr});
      chk($sformatf("R5 memWe v%0d", i), {31'b0, memWe}, {31'b0, VECS[i].st && !VECS[i].eErr});
      chk($sformatf("R2 R4 strobe v%0d", i), {28'b0, memStrobe}, {28'b0, VECS[i].eStrb});
      if (VECS[i].st && !VECS[i].eErr)
        chk($sformatf("R3 memWdata v%0d", i), memWdata, VECS[i].eVal);
      @(negedge clk);
      idleReq();
      memRdata = VECS[i].data;
      #1;
      chk($sformatf("R6 loadValid v%0d", i), {31'b0, loadValid},
          {31'b0, !VECS[i].st && !VECS[i].eErr});
      if (!VECS[i].st && !VECS[i].eErr)
        chk($sformatf("R7 R8 R9 R10 loadData v%0d", i), loadData, VECS[i].eVal);
    end

    // R6: a single load gives a single loadValid pulse
    @(negedge clk); #1;
    chk("R6 no repeat pulse", {31'b0, loadValid}, 32'h0);

    // R12: misaligned-looking store with reqValid low stays quiet
    @(negedge clk);
    reqWrite = 1'b1; reqSize = 2'b10; offset = 16'h0003; storeData = 32'hFFFF_FFFF;
    #1;
    chk("R12 idle addrErr", {31'b0, addrErr}, 32'h0);
    chk("R12 idle memEn", {31'b0, memEn}, 32'h0);
    chk("R12 idle strobe", {28'b0, memStrobe}, 32'h0);
    @(negedge clk); #1;
    chk("R12 idle no loadValid", {31'b0, loadValid}, 32'h0);

    // R11: reset between request and its return cancels loadValid
    @(negedge clk);
    idleReq(); reqValid = 1'b1; reqSize = 2'b10; baseAddr = 32'h100;
    #2 rstN = 1'b0;
    @(negedge clk); #1;
    chk("R11 load cancelled by reset", {31'b0, loadValid}, 32'h0);
    idleReq(); rstN = 1'b1;
    @(negedge clk); #1;
    chk("R11 quiet after reset", {31'b0, loadValid}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule